// File: doc/BRIEF.md
# Dual-Clock Audio Reclocking Buffer

This block sits between a recovered input clock and a free-running local master oscillator. Stereo frames come in as parallel left/right words with a write strobe in the input domain. They leave in the oscillator domain, one frame for each read request issued by a downstream serialiser. The block never follows the input clock. The read side runs only from the local clock, and every word it delivers is a bit-exact copy of a word that was written.

Any rate mismatch between the two clocks shows up as a slow drift of the buffer fill. The block corrects that drift only while the programme material is digitally silent. When the buffer is nearly full, it skips buffered frames. When the buffer is nearly empty, it inserts zero frames. Either correction brings the depth back to the middle.

At start-up, output stays muted until half the buffer has filled. If the input stream stops for long enough, the block flushes the buffer and returns to that muted prefill state. Pointers cross between the domains in Gray code.

Top module: `reclock_fifo`

## Requirements
- R1: After reset, out_valid is 0, mute is 1, and both overflow and underflow are 0.
- R2: Frames read out while running are exactly the frames accepted on the write side, in write order, with all left and right bits unchanged.
- R3: In prefill, each read request returns a frame whose left and right words are both 0, with mute at 1. Output switches to buffered data once the read-side fill reaches DEPTH/2 frames, and mute then drops to 0.
- R4: Every out_req is answered by out_valid=1 in the following cycle, and out_valid is never 1 without a request. While running with an empty buffer, the answer is a zero frame and the sticky underflow flag is set. Output keeps running and does not wait.
- R5: An in_valid frame arriving while DEPTH frames are unread is discarded, and overflow is set. All frames already held are delivered later unchanged.
- R6: A silent frame is a buffered frame whose left and right words are both exactly 0. Silence is declared after sil_len consecutive silent frames have been delivered. A frame with either word non-zero restarts the count.
- R7: When silence is declared and the read-side fill is at least 7/8 of DEPTH, the read side skips buffered frames until the fill is DEPTH/2.
- R8: When silence is declared and the read-side fill is at most DEPTH/8, the next DEPTH/2 minus fill requests are answered with zero frames and the read pointer does not advance.
- R9: Without declared silence, no frame is skipped or inserted, whatever the fill level.
- R10: If no frame is written for TIMEOUT read-clock cycles, the buffered frames are discarded and the block returns to prefill with mute at 1.
- R11: Once set, overflow and underflow stay at 1 until their domain is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered input-domain clock |
| wrst_n | input | 1 | Active-low reset, input domain |
| in_valid | input | 1 | Frame write strobe |
| in_left | input | DATA_W | Left word written |
| in_right | input | DATA_W | Right word written |
| rclk | input | 1 | Local master oscillator clock |
| rrst_n | input | 1 | Active-low reset, oscillator domain |
| sil_len | input | SIL_W | Silent frames needed to declare silence (at least 1) |
| out_req | input | 1 | Read request from the serialiser |
| out_valid | output | 1 | Frame answer, one cycle after out_req |
| out_left | output | DATA_W | Left word delivered |
| out_right | output | DATA_W | Right word delivered |
| mute | output | 1 | High while prefilling or flushing |
| overflow | output | 1 | Sticky: a write was dropped (input domain) |
| underflow | output | 1 | Sticky: a request found the buffer empty while running |

## Verification
The assertions check four things on every cycle: the one-cycle request and answer pairing, zero data whenever mute is high, and that both error flags stay set. How far the fill moves during a skip or an insertion, and whether a correction happens only after silence, depends on the order of frames across both clocks. Only the bench scenarios show those effects, by the position at which a marker frame comes back out. Bit-exact ordering, drop-newest on overflow and the timeout return to prefill are likewise shown only by the directed scenarios.

// File: rtl/reclock_pkg.sv
package reclock_pkg;
    typedef enum logic [1:0] {
        RD_PREFILL = 2'd0,
        RD_RUN     = 2'd1,
        RD_SKIP    = 2'd2,
        RD_FLUSH   = 2'd3
    } rd_state_e;
endpackage

// File: rtl/reclock_gray_sync.sv
module reclock_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    // each binary bit is the parity of the Gray bits at and above it
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign bin_out[i] = ^stage2_q[W-1:i];
    end
endmodule

// File: rtl/reclock_frame_store.sv
module reclock_frame_store #(
    parameter int DATA_W = 24,
    parameter int AW     = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [2*DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [2*DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [2*DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/reclock_wr_ctrl.sv
module reclock_wr_ctrl #(
    parameter int AW = 6
) (
    input  logic        wclk,
    input  logic        wrst_n,
    input  logic        in_valid,
    input  logic [AW:0] rd_bin,
    output logic        we,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wr_gray,
    output logic        overflow
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          ovf;
    } wr_st_t;

    wr_st_t        st_d, st_q;
    logic [PW-1:0] level;
    logic          full;

    always_comb begin
        st_d  = st_q;
        level = st_q.ptr - rd_bin;
        full  = (level == PW'(DEPTH));
        we    = in_valid && !full;
        if (we) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (in_valid && full) begin
            st_d.ovf = 1'b1;
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr    = st_q.ptr[AW-1:0];
    assign wr_gray  = st_q.gray;
    assign overflow = st_q.ovf;
endmodule

// File: rtl/reclock_rd_ctrl.sv
module reclock_rd_ctrl
    import reclock_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int AW      = 6,
    parameter int SIL_W   = 16,
    parameter int TIMEOUT = 4096
) (
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [AW:0]       wr_bin,
    input  logic [SIL_W-1:0]  sil_len,
    input  logic              out_req,
    input  logic [2*DATA_W-1:0] rdata,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rd_gray,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              mute,
    output logic              underflow
);
    localparam int PW       = AW + 1;
    localparam int DEPTH    = 1 << AW;
    localparam int HALF     = DEPTH / 2;
    localparam int NEAR_LO  = DEPTH / 8;
    localparam int NEAR_HI  = DEPTH - DEPTH / 8;
    localparam int TW       = $clog2(TIMEOUT + 1);

    typedef struct packed {
        rd_state_e         state;
        logic [PW-1:0]     rd_ptr;
        logic [PW-1:0]     rd_gray;
        logic [PW-1:0]     wr_seen;
        logic [TW-1:0]     idle_cnt;
        logic [SIL_W-1:0]  sil_cnt;
        logic [PW-1:0]     ins_cnt;
        logic [PW-1:0]     step_cnt;
        logic              out_valid;
        logic [DATA_W-1:0] out_left;
        logic [DATA_W-1:0] out_right;
        logic              mute;
        logic              unf;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [PW-1:0] level;
    logic          stale;
    logic          frame_zero;

    always_comb begin
        st_d       = st_q;
        level      = wr_bin - st_q.rd_ptr;
        stale      = (st_q.idle_cnt == TW'(TIMEOUT)) && (wr_bin == st_q.wr_seen);
        frame_zero = (rdata == '0);

        st_d.out_valid = out_req;
        st_d.out_left  = '0;
        st_d.out_right = '0;

        // input-activity watchdog in the local clock domain
        if (wr_bin != st_q.wr_seen) begin
            st_d.wr_seen  = wr_bin;
            st_d.idle_cnt = '0;
        end else if (st_q.idle_cnt != TW'(TIMEOUT)) begin
            st_d.idle_cnt = st_q.idle_cnt + 1'b1;
        end

        case (st_q.state)
            RD_PREFILL: begin
                if (stale && level != '0) begin
                    st_d.state = RD_FLUSH;
                end else if (level >= PW'(HALF)) begin
                    st_d.state = RD_RUN;
                end
            end
            RD_FLUSH: begin
                // walk one step per cycle so the Gray pointer stays single-step
                if (st_q.rd_ptr != wr_bin) begin
                    st_d.rd_ptr = st_q.rd_ptr + 1'b1;
                end else begin
                    st_d.state = RD_PREFILL;
                end
            end
            RD_SKIP: begin
                st_d.rd_ptr   = st_q.rd_ptr + 1'b1;
                st_d.step_cnt = st_q.step_cnt - 1'b1;
                if (st_q.step_cnt == PW'(1)) begin
                    st_d.state = RD_RUN;
                end
            end
            default: begin
                if (stale) begin
                    st_d.state   = RD_FLUSH;
                    st_d.sil_cnt = '0;
                    st_d.ins_cnt = '0;
                end else if (out_req) begin
                    if (st_q.ins_cnt != '0) begin
                        st_d.ins_cnt = st_q.ins_cnt - 1'b1;
                    end else if (level == '0) begin
                        st_d.unf = 1'b1;
                    end else begin
                        st_d.out_left  = rdata[2*DATA_W-1:DATA_W];
                        st_d.out_right = rdata[DATA_W-1:0];
                        st_d.rd_ptr    = st_q.rd_ptr + 1'b1;
                        if (!frame_zero) begin
                            st_d.sil_cnt = '0;
                        end else if (st_q.sil_cnt != '1) begin
                            st_d.sil_cnt = st_q.sil_cnt + 1'b1;
                        end
                    end
                end else if (st_q.ins_cnt == '0 && st_q.sil_cnt >= sil_len) begin
                    if (level >= PW'(NEAR_HI)) begin
                        st_d.state    = RD_SKIP;
                        st_d.step_cnt = level - PW'(HALF);
                        st_d.sil_cnt  = '0;
                    end else if (level <= PW'(NEAR_LO)) begin
                        st_d.ins_cnt  = PW'(HALF) - level;
                        st_d.sil_cnt  = '0;
                    end
                end
            end
        endcase

        st_d.rd_gray = st_d.rd_ptr ^ (st_d.rd_ptr >> 1);
        st_d.mute    = (st_d.state == RD_PREFILL) || (st_d.state == RD_FLUSH);
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            st_q       <= '0;
            st_q.state <= RD_PREFILL;
            st_q.mute  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr     = st_q.rd_ptr[AW-1:0];
    assign rd_gray   = st_q.rd_gray;
    assign out_valid = st_q.out_valid;
    assign out_left  = st_q.out_left;
    assign out_right = st_q.out_right;
    assign mute      = st_q.mute;
    assign underflow = st_q.unf;
endmodule

// File: rtl/reclock_fifo.sv
module reclock_fifo #(
    parameter int DATA_W  = 24,
    parameter int AW      = 6,
    parameter int SIL_W   = 16,
    parameter int TIMEOUT = 4096
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [SIL_W-1:0]  sil_len,
    input  logic              out_req,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              mute,
    output logic              overflow,
    output logic              underflow
);
    localparam int PW = AW + 1;

    logic              we;
    logic [AW-1:0]     waddr, raddr;
    logic [PW-1:0]     wr_gray, rd_gray, wr_bin_r, rd_bin_w;
    logic [2*DATA_W-1:0] rdata;

    reclock_wr_ctrl #(.AW(AW)) u_wr (
        .wclk     (wclk),
        .wrst_n   (wrst_n),
        .in_valid (in_valid),
        .rd_bin   (rd_bin_w),
        .we       (we),
        .waddr    (waddr),
        .wr_gray  (wr_gray),
        .overflow (overflow)
    );

    reclock_gray_sync #(.W(PW)) u_rd2w (
        .clk     (wclk),
        .rst_n   (wrst_n),
        .gray_in (rd_gray),
        .bin_out (rd_bin_w)
    );

    reclock_gray_sync #(.W(PW)) u_w2rd (
        .clk     (rclk),
        .rst_n   (rrst_n),
        .gray_in (wr_gray),
        .bin_out (wr_bin_r)
    );

    reclock_frame_store #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata ({in_left, in_right}),
        .raddr (raddr),
        .rdata (rdata)
    );

    reclock_rd_ctrl #(
        .DATA_W(DATA_W), .AW(AW), .SIL_W(SIL_W), .TIMEOUT(TIMEOUT)
    ) u_rd (
        .rclk      (rclk),
        .rrst_n    (rrst_n),
        .wr_bin    (wr_bin_r),
        .sil_len   (sil_len),
        .out_req   (out_req),
        .rdata     (rdata),
        .raddr     (raddr),
        .rd_gray   (rd_gray),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right),
        .mute      (mute),
        .underflow (underflow)
    );
endmodule

// File: rtl/reclock_fifo_chk.sv
module reclock_fifo_chk #(
    parameter int DATA_W = 24
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              rclk,
    input logic              rrst_n,
    input logic              out_req,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              mute,
    input logic              overflow,
    input logic              underflow
);
    assert_answer_next_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        out_req |=> out_valid);

    assert_no_spurious_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        !out_req |=> !out_valid);

    assert_muted_is_zero_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
        (out_valid && mute) |-> (out_left == '0 && out_right == '0));

    assert_unf_sticky_R11: assert property (@(posedge rclk) disable iff (!rrst_n)
        underflow |=> underflow);

    assert_ovf_sticky_R11: assert property (@(posedge wclk) disable iff (!wrst_n)
        overflow |=> overflow);
endmodule

bind reclock_fifo reclock_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .wclk      (wclk),
    .wrst_n    (wrst_n),
    .rclk      (rclk),
    .rrst_n    (rrst_n),
    .out_req   (out_req),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .mute      (mute),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/sim_reclock_fifo.sv
module sim_reclock_fifo;
    localparam int DW = 24;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int TMO = 400;

    logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic in_valid = 0, out_req = 0;
    logic [DW-1:0] in_left = '0, in_right = '0;
    logic [15:0] sil_len = 16'd4;
    logic out_valid, mute, overflow, underflow;
    logic [DW-1:0] out_left, out_right;

    int total = 0, bad = 0;
    logic [2*DW-1:0] model [$];
    logic [2*DW-1:0] got;

    localparam logic [2*DW-1:0] VEC [12] = '{
        {24'h7FFFFF, 24'h800000}, {24'h000000, 24'h000001},
        {24'hFFFFFF, 24'hFFFFFF}, {24'h000001, 24'h000000},
        {24'hA5A5A5, 24'h5A5A5A}, {24'h123456, 24'h654321},
        {24'h800000, 24'h7FFFFF}, {24'h00FF00, 24'hFF00FF},
        {24'hDEADBE, 24'h0BEEF0}, {24'h000000, 24'h800000},
        {24'h3C3C3C, 24'hC3C3C3}, {24'h010203, 24'h040506}
    };

    always #2 rclk = ~rclk;
    always #5 wclk = ~wclk;

    reclock_fifo #(.DATA_W(DW), .AW(AW), .SIL_W(16), .TIMEOUT(TMO)) u0 (
        .wclk(wclk), .wrst_n(wrst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .rclk(rclk), .rrst_n(rrst_n), .sil_len(sil_len),
        .out_req(out_req), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .mute(mute), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [2*DW-1:0] f);
        @(negedge wclk);
        in_valid = 1'b1;
        {in_left, in_right} = f;
        @(negedge wclk);
        in_valid = 1'b0;
        repeat (8) @(negedge rclk);
    endtask

    task automatic take();
        @(negedge rclk);
        out_req = 1'b1;
        @(negedge rclk);
        out_req = 1'b0;
        chk("R4 valid answer", 64'(out_valid), 64'd1);
        got = {out_left, out_right};
        repeat (10) @(negedge rclk);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge rclk);
        // R1 reset values
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 mute", 64'(mute), 64'd1);
        chk("R1 flags", 64'({overflow, underflow}), 64'd0);
        wrst_n = 1; rrst_n = 1;
        repeat (4) @(negedge rclk);

        // R3 prefill: 7 frames not enough
        for (int i = 0; i < 7; i++) begin
            put({24'(i + 1), 24'(100 + i)});
            model.push_back({24'(i + 1), 24'(100 + i)});
        end
        take();
        chk("R3 zero while prefilling", 64'(got), 64'd0);
        chk("R3 mute while prefilling", 64'(mute), 64'd1);
        put({24'd8, 24'd107});
        model.push_back({24'd8, 24'd107});
        take();
        chk("R3 first frame after prefill", 64'(got), 64'(model.pop_front()));
        chk("R3 unmuted", 64'(mute), 64'd0);

        // R2 vector table walk, steady mid-level fill
        for (int i = 0; i < 12; i++) begin
            put(VEC[i]);
            model.push_back(VEC[i]);
            take();
            chk("R2 bit-exact order", 64'(got), 64'(model.pop_front()));
        end

        // R9 drain non-silent frames through low fill: no insertion
        while (model.size() > 0) begin
            take();
            chk("R9 no correction without silence", 64'(got), 64'(model.pop_front()));
        end
        // R4 empty while running
        take();
        chk("R4 zero frame on empty", 64'(got), 64'd0);
        chk("R4 underflow set", 64'(underflow), 64'd1);
        chk("R4 still running", 64'(mute), 64'd0);

        // R10 input timeout
        repeat (TMO + 100) @(negedge rclk);
        chk("R10 mute after timeout", 64'(mute), 64'd1);
        take();
        chk("R10 zero after timeout", 64'(got), 64'd0);

        // R5 overflow drops newest
        for (int i = 0; i < DEPTH + 1; i++) put({24'(200 + i), 24'(300 + i)});
        chk("R5 overflow set", 64'(overflow), 64'd1);
        for (int i = 0; i < DEPTH; i++) begin
            take();
            chk("R5 held frames intact", 64'(got), 64'({24'(200 + i), 24'(300 + i)}));
        end
        take();
        chk("R5 newest dropped", 64'(got), 64'd0);
        chk("R11 overflow sticky", 64'(overflow), 64'd1);

        // R7 skip while near full and silent
        repeat (TMO + 100) @(negedge rclk);
        for (int i = 0; i < DEPTH; i++) put('0);
        for (int i = 0; i < 4; i++) begin
            take();
            chk("R6 silent frame delivered", 64'(got), 64'd0);
            put('0);
        end
        for (int i = 0; i < 4; i++) put({24'(500 + i), 24'h0});
        for (int i = 0; i < 9; i++) take();
        chk("R7 zeros before marker", 64'(got), 64'd0);
        take();
        chk("R7 marker after skip", 64'(got), 64'({24'd500, 24'h0}));

        // R8 insert while near empty and silent
        repeat (TMO + 100) @(negedge rclk);
        for (int i = 0; i < DEPTH / 2; i++) put('0);
        for (int i = 0; i < 6; i++) take();
        put({24'h0, 24'hABCDEF});
        for (int i = 0; i < 8; i++) begin
            take();
            chk("R8 inserted or buffered zero", 64'(got), 64'd0);
        end
        take();
        chk("R8 marker after insertion", 64'(got), 64'({24'h0, 24'hABCDEF}));
        chk("R11 underflow sticky", 64'(underflow), 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule